// File: doc/BRIEF.md
# Port-Based Forwarding Table Flush Engine

This block removes forwarding state that belongs to a chosen set of switch ports. A controller gives it a 3-bit port mask and a mode, then pulses `start_i`. The engine reads every table entry in turn and decides, for each one, whether it must change. Entries that change are written back. Entries that stay the same are not written.

Only address entries are considered. Multicast entries lose the flushed ports from their port map. An entry whose port map becomes empty is freed. A unicast entry is freed when its egress port is one of the flushed ports. In group-only mode, unicast entries are left alone and the broadcast entry is spared.

The table is outside the block. It is reached through a read port with one cycle of latency and a write port that commits at the clock edge. Completion is signalled by a single-cycle `done_o` pulse.

Top module: `flush_engine`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `rd_en_o` and `wr_en_o` are all low.
- R2: Once started, the engine reads indices 0 to DEPTH-1, each exactly once and in increasing order. Reads are issued on alternate cycles, and the first read comes in the cycle after `start_i` is sampled.
- R3: Only entries whose kind field (bits 61:60) is 1 or 3 can be modified. Kinds 0 and 2 are never written.
- R4: An entry with the group bit (bit 40) set is left unchanged when its port map (bits 68:66) shares no bit with the flush mask.
- R5: A group entry whose port map intersects the flush mask, but is not covered by it, is rewritten with the masked bits cleared from its port map. All other bits stay as they were.
- R6: A group entry whose port map lies entirely inside the flush mask has its kind field set to 0. All other bits keep their values.
- R7: A unicast entry (bit 40 clear) has its kind field set to 0 when its port number (bits 67:66, values 0 to 2) selects a set bit of the flush mask. Port number 3 never matches.
- R8: In group-only mode, unicast entries are never changed, and an entry whose 48-bit address (bits 47:0) is all ones is never changed. In all-address mode, the all-ones entry is pruned like any other group entry.
- R9: A write happens only for an entry whose new contents differ from the old ones. The write carries the index of that entry and is presented in the cycle after the entry's data arrives.
- R10: `done_o` is high for exactly one cycle, 2*DEPTH+1 clock edges after the edge that samples `start_i`. `busy_o` is high throughout the walk. A `start_i` pulse seen while busy is ignored, and the mask and mode latched at start hold until the walk ends.
- R11: A zero flush mask completes the walk without writing any entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a flush; sampled only while idle |
| drop_mask_i | input | 3 | Ports to remove, one bit per port |
| group_only_i | input | 1 | 1: touch group entries only, spare all-ones address |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse at the end of a walk |
| rd_en_o | output | 1 | Table read request |
| rd_idx_o | output | $clog2(DEPTH) | Index being read |
| rd_entry_i | input | 72 | Entry data, valid one cycle after the request |
| wr_en_o | output | 1 | Table write strobe |
| wr_idx_o | output | $clog2(DEPTH) | Index being written |
| wr_entry_o | output | 72 | New entry contents |

## Verification
The read of entry k is issued 2k+1 edges after the start edge, and its data returns one edge later. Any write for that entry is presented in the next cycle and commits at the following edge. `done_o` rises 2*DEPTH+1 edges after start, so every table write has already landed when the pulse is seen. The bench drives and samples on the falling edge, and it counts falling edges from the start strobe, so the completion time is checked as an exact number rather than a bound. Each result is read from the bench's table model only after the done pulse.

// File: rtl/flush_pkg.sv
package flush_pkg;
  localparam int ENT_W     = 72;
  localparam int KIND_LO   = 60;
  localparam int GROUP_BIT = 40;
  localparam int PMAP_LO   = 66;
  localparam int NPORT     = 3;
  localparam int MAC_W     = 48;

  typedef enum logic [1:0] {
    K_FREE  = 2'd0,
    K_ADDR  = 2'd1,
    K_VLAN  = 2'd2,
    K_VADDR = 2'd3
  } kind_e;

  typedef logic [ENT_W-1:0] entry_t;
  typedef logic [NPORT-1:0] pmap_t;

  typedef struct packed {
    logic   touch;
    entry_t img;
  } verdict_t;

  function automatic logic holds_addr(entry_t e);
    return (e[KIND_LO +: 2] == K_ADDR) || (e[KIND_LO +: 2] == K_VADDR);
  endfunction

  function automatic pmap_t prune(pmap_t have, pmap_t drop);
    return have & ~drop;
  endfunction

  function automatic logic port_hit(logic [1:0] pn, pmap_t drop);
    logic [3:0] ext;
    ext = {1'b0, drop};
    return ext[pn];
  endfunction

  // Decide the fate of one entry under a flush mask and mode.
  function automatic verdict_t judge(entry_t e, pmap_t drop, logic grp_only);
    verdict_t v;
    pmap_t    have;
    logic     is_bcast;
    v.touch  = 1'b0;
    v.img    = e;
    have     = e[PMAP_LO +: NPORT];
    is_bcast = &e[MAC_W-1:0];
    if (holds_addr(e) && (drop != '0)) begin
      if (e[GROUP_BIT]) begin
        if (!(grp_only && is_bcast) && ((have & drop) != '0)) begin
          v.touch = 1'b1;
          if (prune(have, drop) == '0) v.img[KIND_LO +: 2] = K_FREE;
          else                         v.img[PMAP_LO +: NPORT] = prune(have, drop);
        end
      end else if (!grp_only && port_hit(e[PMAP_LO +: 2], drop)) begin
        v.touch = 1'b1;
        v.img[KIND_LO +: 2] = K_FREE;
      end
    end
    return v;
  endfunction
endpackage

// File: rtl/flush_walker.sv
module flush_walker #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             rd_en_o,
  output logic             eval_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);
  typedef enum logic [1:0] {W_IDLE, W_RD, W_EV, W_FIN} wstate_e;

  wstate_e          state;
  logic [IDX_W-1:0] idx;
  logic             last;
  logic             done_q;

  assign last     = (idx == IDX_W'(DEPTH - 1));
  assign accept_o = start_i && (state == W_IDLE);
  assign busy_o   = (state != W_IDLE);
  assign rd_en_o  = (state == W_RD);
  assign eval_o   = (state == W_EV);
  assign idx_o    = idx;
  assign done_o   = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= W_IDLE;
      idx    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (state == W_FIN);
      case (state)
        W_IDLE: if (start_i) begin
          state <= W_RD;
          idx   <= '0;
        end
        W_RD:   state <= W_EV;
        W_EV:   if (last) state <= W_FIN;
                else begin
                  state <= W_RD;
                  idx   <= idx + IDX_W'(1);
                end
        default: state <= W_IDLE;
      endcase
    end
  end

  // R2
  reads_spaced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |=> !rd_en_o);
  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_o && idx_o != '0) |-> (idx_o == IDX_W'($past(idx_o, 2) + 1'b1)));
  // R2
  first_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (rd_en_o && idx_o == '0));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R10
  done_after_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));
endmodule

// File: rtl/flush_writeback.sv
module flush_writeback
  import flush_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval_i,
  input  logic [IDX_W-1:0] idx_i,
  input  entry_t           rd_entry_i,
  input  pmap_t            drop_i,
  input  logic             grp_only_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output entry_t           wr_entry_o
);
  verdict_t vd;

  always_comb vd = judge(rd_entry_i, drop_i, grp_only_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en_o    <= 1'b0;
      wr_idx_o   <= '0;
      wr_entry_o <= '0;
    end else begin
      wr_en_o <= eval_i && vd.touch;
      if (eval_i) begin
        wr_idx_o   <= idx_i;
        wr_entry_o <= vd.img;
      end
    end
  end

  // R9
  write_after_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> ($past(eval_i) && wr_idx_o == $past(idx_i)));
  // R9
  write_differs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (wr_entry_o != $past(rd_entry_i)));
  // R6 R7
  freed_or_pruned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> ((wr_entry_o[KIND_LO +: 2] == K_FREE) ||
                 (wr_entry_o[PMAP_LO +: NPORT] != $past(rd_entry_i[PMAP_LO +: NPORT]))));
  // R8
  group_only_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && grp_only_i) |-> (wr_entry_o[GROUP_BIT] && !(&wr_entry_o[MAC_W-1:0])));
endmodule

// File: rtl/flush_engine.sv
module flush_engine
  import flush_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [NPORT-1:0]      drop_mask_i,
  input  logic                  group_only_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  rd_en_o,
  output logic [IDX_W-1:0]      rd_idx_o,
  input  logic [ENT_W-1:0]      rd_entry_i,
  output logic                  wr_en_o,
  output logic [IDX_W-1:0]      wr_idx_o,
  output logic [ENT_W-1:0]      wr_entry_o
);
  logic             accept;
  logic             eval;
  logic [IDX_W-1:0] idx;
  pmap_t            drop_q;
  logic             grp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drop_q <= '0;
      grp_q  <= 1'b0;
    end else if (accept) begin
      drop_q <= drop_mask_i;
      grp_q  <= group_only_i;
    end
  end

  assign rd_idx_o = idx;

  flush_walker #(.DEPTH(DEPTH)) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .accept_o (accept),
    .busy_o   (busy_o),
    .rd_en_o  (rd_en_o),
    .eval_o   (eval),
    .idx_o    (idx),
    .done_o   (done_o)
  );

  flush_writeback #(.IDX_W(IDX_W)) u_wb (
    .clk        (clk),
    .rst_n      (rst_n),
    .eval_i     (eval),
    .idx_i      (idx),
    .rd_entry_i (rd_entry_i),
    .drop_i     (drop_q),
    .grp_only_i (grp_q),
    .wr_en_o    (wr_en_o),
    .wr_idx_o   (wr_idx_o),
    .wr_entry_o (wr_entry_o)
  );

  // R10
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(drop_q) && $stable(grp_q)));
  // R11
  zero_mask_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (drop_q != '0));
  // R3
  addr_kind_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> $past(rd_entry_i[KIND_LO]));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!rd_en_o && !eval));
endmodule

// File: tb/tb_flush_engine.sv
`timescale 1ns/1ps
module tb_flush_engine;
  localparam int N = 16;
  localparam logic [47:0] GM = 48'h01005E0000FB;
  localparam logic [47:0] UM = 48'h021122334455;
  localparam logic [47:0] BC = 48'hFFFFFFFFFFFF;

  function automatic logic [71:0] mk(input logic [1:0] kind, input logic [2:0] pm,
                                     input logic [47:0] mac);
    logic [71:0] e;
    e = '0;
    e[47:0]  = mac;
    e[59:48] = 12'hA5C;
    e[61:60] = kind;
    e[68:66] = pm;
    e[71:69] = 3'b101;
    return e;
  endfunction

  typedef struct packed {
    logic [71:0] init;
    logic [2:0]  drop;
    logic        grp;
    logic [71:0] want;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{mk(0,7,GM), 3'd7, 1'b0, mk(0,7,GM), "R3"},
    '{mk(2,7,GM), 3'd7, 1'b0, mk(2,7,GM), "R3"},
    '{mk(1,1,GM), 3'd6, 1'b0, mk(1,1,GM), "R4"},
    '{mk(1,7,GM), 3'd2, 1'b0, mk(1,5,GM), "R5"},
    '{mk(3,3,GM), 3'd3, 1'b0, mk(0,3,GM), "R6"},
    '{mk(1,1,UM), 3'd2, 1'b0, mk(0,1,UM), "R7"},
    '{mk(1,1,UM), 3'd5, 1'b0, mk(1,1,UM), "R7"},
    '{mk(3,3,UM), 3'd7, 1'b0, mk(3,3,UM), "R7"},
    '{mk(1,2,UM), 3'd4, 1'b1, mk(1,2,UM), "R8"},
    '{mk(1,7,BC), 3'd7, 1'b1, mk(1,7,BC), "R8"},
    '{mk(1,7,BC), 3'd1, 1'b0, mk(1,6,BC), "R8"},
    '{mk(3,6,GM), 3'd4, 1'b1, mk(3,2,GM), "R5"},
    '{mk(1,7,GM), 3'd0, 1'b0, mk(1,7,GM), "R11"},
    '{mk(1,0,UM), 3'd0, 1'b0, mk(1,0,UM), "R11"},
    '{mk(3,2,UM), 3'd4, 1'b0, mk(0,2,UM), "R7"}
  };

  logic        clk = 1'b0;
  logic        rst_n, start, grp, ld_en, mon_clr;
  logic [2:0]  drop;
  logic [3:0]  ld_idx;
  logic [71:0] ld_data;
  logic        busy_o, done_o, rd_en_o, wr_en_o;
  logic [3:0]  rd_idx_o, wr_idx_o;
  logic [71:0] rd_q, wr_entry_o;
  logic [71:0] mem [N];
  logic [3:0]  rd_log [N];
  int          wr_cnt, rd_cnt, done_cnt;
  logic [3:0]  last_wr;
  int          checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  flush_engine #(.DEPTH(N)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .drop_mask_i(drop),
    .group_only_i(grp), .busy_o(busy_o), .done_o(done_o),
    .rd_en_o(rd_en_o), .rd_idx_o(rd_idx_o), .rd_entry_i(rd_q),
    .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .wr_entry_o(wr_entry_o)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else begin
      if (ld_en)   mem[ld_idx]   <= ld_data;
      if (wr_en_o) mem[wr_idx_o] <= wr_entry_o;
    end
    if (rd_en_o) rd_q <= mem[rd_idx_o];
    if (mon_clr) begin
      wr_cnt <= 0; rd_cnt <= 0; done_cnt <= 0; last_wr <= '0;
    end else begin
      if (wr_en_o) begin wr_cnt <= wr_cnt + 1; last_wr <= wr_idx_o; end
      if (rd_en_o) begin
        if (rd_cnt < N) rd_log[rd_cnt] <= rd_idx_o;
        rd_cnt <= rd_cnt + 1;
      end
      if (done_o) done_cnt <= done_cnt + 1;
    end
  end

  task automatic chk(input logic ok, input logic [23:0] tag,
                     input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [3:0] i, input logic [71:0] d);
    @(negedge clk); ld_en = 1'b1; ld_idx = i; ld_data = d;
    @(negedge clk); ld_en = 1'b0;
  endtask

  // Start a walk, then wait for done with a watchdog bound.
  task automatic run(input logic [2:0] d, input logic g, output int cyc);
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0; start = 1'b1; drop = d; grp = g;
    @(negedge clk); start = 1'b0;
    chk(busy_o == 1'b1, "R10", 72'(busy_o), 72'd1);
    cyc = 0;
    while (!done_o && cyc < 300) begin
      @(negedge clk); cyc++;
    end
    if (cyc >= 300) chk(1'b0, "R10", 72'(cyc), 72'(2*N+1)); // watchdog
  endtask

  initial begin
    int cyc;
    rst_n = 1'b0; start = 1'b0; grp = 1'b0; drop = '0;
    ld_en = 1'b0; ld_idx = '0; ld_data = '0; mon_clr = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; mon_clr = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy_o && !done_o, "R1", {70'd0, busy_o, done_o}, 72'd0);
    chk(!rd_en_o && !wr_en_o, "R1", {70'd0, rd_en_o, wr_en_o}, 72'd0);

    // Vector table: one entry at index 5, all others free.
    for (int v = 0; v < NV; v++) begin
      load(4'd5, VECS[v].init);
      run(VECS[v].drop, VECS[v].grp, cyc);
      chk(mem[5] == VECS[v].want, VECS[v].tag, mem[5], VECS[v].want);
      // R9 write only when content changes
      chk(wr_cnt == ((VECS[v].want != VECS[v].init) ? 1 : 0), "R9",
          72'(wr_cnt), 72'((VECS[v].want != VECS[v].init) ? 1 : 0));
      if (wr_cnt != 0) chk(last_wr == 4'd5, "R9", 72'(last_wr), 72'd5);
      // R10 done timing
      chk(cyc == 2*N+1, "R10", 72'(cyc), 72'(2*N+1));
      load(4'd5, '0);
    end

    // Several entries in one walk; also the order of reads (R2).
    load(4'd0,  mk(1,4,GM));
    load(4'd3,  mk(1,0,UM));
    load(4'd9,  mk(3,6,GM));
    load(4'd15, mk(1,2,UM));
    run(3'b100, 1'b0, cyc);
    chk(mem[0]  == mk(0,4,GM), "R6", mem[0],  mk(0,4,GM));
    chk(mem[3]  == mk(1,0,UM), "R7", mem[3],  mk(1,0,UM));
    chk(mem[9]  == mk(3,2,GM), "R5", mem[9],  mk(3,2,GM));
    chk(mem[15] == mk(0,2,UM), "R7", mem[15], mk(0,2,UM));
    chk(wr_cnt == 3, "R9", 72'(wr_cnt), 72'd3);
    chk(rd_cnt == N, "R2", 72'(rd_cnt), 72'(N));
    for (int i = 0; i < N; i++)
      chk(rd_log[i] == 4'(i), "R2", 72'(rd_log[i]), 72'(i));

    // Start while busy is ignored (R10).
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0; start = 1'b1; drop = 3'b001; grp = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1; drop = 3'b111;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!done_o && cyc < 300) begin @(negedge clk); cyc++; end
    if (cyc >= 300) chk(1'b0, "R10", 72'(cyc), 72'(2*N+1)); // watchdog
    repeat (40) @(negedge clk);
    chk(done_cnt == 1, "R10", 72'(done_cnt), 72'd1);
    chk(rd_cnt == N, "R10", 72'(rd_cnt), 72'(N));
    chk(mem[9] == mk(3,2,GM), "R10", mem[9], mk(3,2,GM));
    chk(wr_cnt == 0, "R10", 72'(wr_cnt), 72'd0);
    chk(!busy_o, "R10", 72'(busy_o), 72'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule